// File: doc/BRIEF.md
# Per-Warp Register Scoreboard Issue Slot

This block sits between the issue stage of a multi-warp processor pipeline and its two kinds of functional unit. It holds one instruction in a single slot. It keeps a ready bit for every architectural register of every warp. It releases the held instruction to the execute unit (EXE) or to the load/store unit (LSU) once none of the instruction's source registers is still waiting on an older result. A dispatched instruction marks its destination register as not ready in its own warp. A writeback port makes that register ready again.

The slot is driven by a two-state controller. In `SLOT_EMPTY` nothing is held. The transition *capture* (a valid input) moves it to `SLOT_HELD`. In `SLOT_HELD` three things can happen. The transition *dispatch* releases the instruction and returns to `SLOT_EMPTY` when no input is offered. The transition *dispatch-and-refill* releases the instruction and captures a new one in the same cycle, so it stays in `SLOT_HELD`. The self-loop *hold* keeps the instruction and raises the stall signal toward the earlier stages.

A memory instruction also waits while the LSU reports that it is busy. The EXE path is never busy. Register 0 is not tracked: it is never checked as a source and never marked as a destination. A destination that is absent is signalled by a valid bit.

Top module: `reg_scoreboard_issue`

## Requirements
- R1: After reset every register of every warp is ready, the slot is empty, and `exe_dispatch`, `lsu_dispatch` and `issue_stall` are all 0.
- R2: A source index of 0 is never checked, and a destination index of 0 is never marked not ready.
- R3: A held instruction dispatches only when each checked source (rs1, rs2) is ready in the table of its own warp. A register marked in one warp does not block another warp.
- R4: On dispatch, a present destination rd > 0 becomes not ready in its warp's table from the next cycle. A writeback (`wb_valid`, `wb_warp`, `wb_rd`) makes it ready again from the cycle after the writeback.
- R5: A held instruction with `in_is_mem`=1 dispatches on `lsu_dispatch`; any other instruction dispatches on `exe_dispatch`. The two are never high together.
- R6: A memory instruction is held while `lsu_busy`=1 and dispatches in the first cycle it is low. An instruction for the EXE unit ignores `lsu_busy`.
- R7: `issue_stall` is 1 exactly when an instruction is held and cannot dispatch in that cycle. A held instruction stays unchanged while stalled.
- R8: When a writeback and a dispatch name the same warp and register in the same cycle, the register ends up not ready.
- R9: When `in_rd_valid`=0 the instruction marks no register, whatever `in_rd` carries.
- R10: The slot accepts a new instruction in the same cycle the held one dispatches. An instruction offered while `issue_stall`=1 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_warp | input | $clog2(NUM_WARPS) | Warp of the offered instruction |
| in_rs1 | input | $clog2(NUM_REGS) | First source register index |
| in_rs2 | input | $clog2(NUM_REGS) | Second source register index |
| in_rd_valid | input | 1 | Instruction writes a destination |
| in_rd | input | $clog2(NUM_REGS) | Destination register index |
| in_is_mem | input | 1 | Load or store, goes to the LSU |
| lsu_busy | input | 1 | LSU cannot take an instruction this cycle |
| wb_valid | input | 1 | A writeback completes this cycle |
| wb_warp | input | $clog2(NUM_WARPS) | Warp of the writeback |
| wb_rd | input | $clog2(NUM_REGS) | Register made ready by the writeback |
| exe_dispatch | output | 1 | Held instruction is released to EXE this cycle |
| lsu_dispatch | output | 1 | Held instruction is released to the LSU this cycle |
| issue_stall | output | 1 | Held instruction is blocked; upstream must wait |

## Verification
The bench builds the block with NUM_WARPS=4 and NUM_REGS=8. With these values every warp/register pair outside register 0 can be swept one by one. For each pair the sweep marks the register, shows that a second warp passes through, stalls a dependent load on the same warp, and then releases it by a writeback. The small table also makes the corner cases short to reach: the writeback that meets a dispatch in the same cycle, the absent destination, an LSU busy for several cycles, and an instruction dropped while the slot is stalled.

// File: rtl/scoreboard_pkg.sv
package scoreboard_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/sb_ready_table.sv
module sb_ready_table #(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 32,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int RW = $clog2(NUM_REGS),
    localparam int NB = NUM_WARPS * NUM_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [WW-1:0] set_warp,
    input  logic [RW-1:0] set_reg,
    input  logic          clr_en,
    input  logic [WW-1:0] clr_warp,
    input  logic [RW-1:0] clr_reg,
    output logic [NB-1:0] ready_bits
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        localparam logic [WW-1:0] WID = WW'(w);
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            localparam logic [RW-1:0] RID = RW'(r);
            if (r == 0) begin : g_zero
                assign ready_bits[w*NUM_REGS + r] = 1'b1;
            end else begin : g_tracked
                logic bit_q;
                logic hit_clr;
                logic hit_set;
                assign hit_clr = clr_en && (clr_warp == WID) && (clr_reg == RID);
                assign hit_set = set_en && (set_warp == WID) && (set_reg == RID);
                always_ff @(posedge clk) begin
                    if (!rst_n)       bit_q <= 1'b1;
                    else if (hit_clr) bit_q <= 1'b0;
                    else if (hit_set) bit_q <= 1'b1;
                end
                assign ready_bits[w*NUM_REGS + r] = bit_q;
            end
        end
    end

endmodule

// File: rtl/sb_src_check.sv
module sb_src_check #(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 32,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int RW = $clog2(NUM_REGS),
    localparam int NB = NUM_WARPS * NUM_REGS
) (
    input  logic [NB-1:0] ready_bits,
    input  logic [WW-1:0] warp,
    input  logic [RW-1:0] rs1,
    input  logic [RW-1:0] rs2,
    output logic          srcs_ready
);

    logic [NUM_REGS-1:0] warp_row;
    logic                ok1;
    logic                ok2;

    always_comb begin
        warp_row = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (warp == WW'(w)) warp_row = ready_bits[w*NUM_REGS +: NUM_REGS];
        end
        ok1 = (rs1 == '0) || warp_row[rs1];
        ok2 = (rs2 == '0) || warp_row[rs2];
        srcs_ready = ok1 && ok2;
    end

endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
    import scoreboard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic srcs_ready,
    input  logic held_is_mem,
    input  logic lsu_busy,
    output logic capture,
    output logic exe_dispatch,
    output logic lsu_dispatch,
    output logic issue_stall
);

    slot_state_e state_q;
    slot_state_e state_d;
    logic        can_go;

    assign can_go = srcs_ready && (!held_is_mem || !lsu_busy);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d      = state_q;
        capture      = 1'b0;
        exe_dispatch = 1'b0;
        lsu_dispatch = 1'b0;
        issue_stall  = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                capture = in_valid;
                if (in_valid) state_d = SLOT_HELD;
            end
            SLOT_HELD: begin
                if (can_go) begin
                    exe_dispatch = !held_is_mem;
                    lsu_dispatch = held_is_mem;
                    capture      = in_valid;
                    state_d      = in_valid ? SLOT_HELD : SLOT_EMPTY;
                end else begin
                    issue_stall = 1'b1;
                end
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

endmodule

// File: rtl/reg_scoreboard_issue.sv
module reg_scoreboard_issue #(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 32,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int RW = $clog2(NUM_REGS),
    localparam int NB = NUM_WARPS * NUM_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [WW-1:0] in_warp,
    input  logic [RW-1:0] in_rs1,
    input  logic [RW-1:0] in_rs2,
    input  logic          in_rd_valid,
    input  logic [RW-1:0] in_rd,
    input  logic          in_is_mem,
    input  logic          lsu_busy,
    input  logic          wb_valid,
    input  logic [WW-1:0] wb_warp,
    input  logic [RW-1:0] wb_rd,
    output logic          exe_dispatch,
    output logic          lsu_dispatch,
    output logic          issue_stall
);

    logic [WW-1:0] slot_warp;
    logic [RW-1:0] slot_rs1;
    logic [RW-1:0] slot_rs2;
    logic          slot_rd_valid;
    logic [RW-1:0] slot_rd;
    logic          slot_is_mem;

    logic          capture;
    logic          srcs_ready;
    logic [NB-1:0] ready_bits;
    logic          mark_en;
    logic          release_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_warp     <= '0;
            slot_rs1      <= '0;
            slot_rs2      <= '0;
            slot_rd_valid <= 1'b0;
            slot_rd       <= '0;
            slot_is_mem   <= 1'b0;
        end else if (capture) begin
            slot_warp     <= in_warp;
            slot_rs1      <= in_rs1;
            slot_rs2      <= in_rs2;
            slot_rd_valid <= in_rd_valid;
            slot_rd       <= in_rd;
            slot_is_mem   <= in_is_mem;
        end
    end

    assign mark_en    = (exe_dispatch || lsu_dispatch) && slot_rd_valid && (slot_rd != '0);
    assign release_en = wb_valid && (wb_rd != '0);

    sb_ready_table #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (release_en),
        .set_warp   (wb_warp),
        .set_reg    (wb_rd),
        .clr_en     (mark_en),
        .clr_warp   (slot_warp),
        .clr_reg    (slot_rd),
        .ready_bits (ready_bits)
    );

    sb_src_check #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_check (
        .ready_bits (ready_bits),
        .warp       (slot_warp),
        .rs1        (slot_rs1),
        .rs2        (slot_rs2),
        .srcs_ready (srcs_ready)
    );

    sb_issue_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .srcs_ready   (srcs_ready),
        .held_is_mem  (slot_is_mem),
        .lsu_busy     (lsu_busy),
        .capture      (capture),
        .exe_dispatch (exe_dispatch),
        .lsu_dispatch (lsu_dispatch),
        .issue_stall  (issue_stall)
    );

endmodule

// File: rtl/sb_issue_checker.sv
module sb_issue_checker #(
    parameter int NUM_WARPS = 32,
    parameter int NUM_REGS  = 32,
    localparam int WW = $clog2(NUM_WARPS),
    localparam int RW = $clog2(NUM_REGS),
    localparam int NB = NUM_WARPS * NUM_REGS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lsu_busy,
    input logic          exe_dispatch,
    input logic          lsu_dispatch,
    input logic          issue_stall,
    input logic [WW-1:0] slot_warp,
    input logic [RW-1:0] slot_rs1,
    input logic [RW-1:0] slot_rs2,
    input logic          slot_rd_valid,
    input logic [RW-1:0] slot_rd,
    input logic          slot_is_mem,
    input logic [NB-1:0] ready_bits
);

    logic marks;
    int   mark_idx;
    assign marks    = (exe_dispatch || lsu_dispatch) && slot_rd_valid && (slot_rd != '0);
    assign mark_idx = int'(slot_warp) * NUM_REGS + int'(slot_rd);

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(exe_dispatch && lsu_dispatch)); // R5

    AST_STALL_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |-> !exe_dispatch && !lsu_dispatch); // R7

    AST_LSU_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        lsu_dispatch |-> !lsu_busy); // R6

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall |=> $stable(slot_warp) && $stable(slot_rs1) && $stable(slot_rs2)
                        && $stable(slot_rd) && $stable(slot_rd_valid) && $stable(slot_is_mem)); // R7

    AST_DEST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        marks |=> !ready_bits[$past(mark_idx)]); // R4

    AST_REG0_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_bits[int'(slot_warp) * NUM_REGS]); // R2

endmodule

bind reg_scoreboard_issue sb_issue_checker #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lsu_busy      (lsu_busy),
    .exe_dispatch  (exe_dispatch),
    .lsu_dispatch  (lsu_dispatch),
    .issue_stall   (issue_stall),
    .slot_warp     (slot_warp),
    .slot_rs1      (slot_rs1),
    .slot_rs2      (slot_rs2),
    .slot_rd_valid (slot_rd_valid),
    .slot_rd       (slot_rd),
    .slot_is_mem   (slot_is_mem),
    .ready_bits    (ready_bits)
);

// File: tb/tb_reg_scoreboard_issue.sv
module tb_reg_scoreboard_issue;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int NR = 8;
    localparam int WW = $clog2(NW);
    localparam int RW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [WW-1:0] in_warp;
    logic [RW-1:0] in_rs1, in_rs2, in_rd;
    logic          in_rd_valid, in_is_mem, lsu_busy;
    logic          wb_valid;
    logic [WW-1:0] wb_warp;
    logic [RW-1:0] wb_rd;
    logic          exe_dispatch, lsu_dispatch, issue_stall;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_scoreboard_issue #(.NUM_WARPS(NW), .NUM_REGS(NR)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_warp(in_warp), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_rd_valid(in_rd_valid), .in_rd(in_rd), .in_is_mem(in_is_mem),
        .lsu_busy(lsu_busy), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_rd(wb_rd),
        .exe_dispatch(exe_dispatch), .lsu_dispatch(lsu_dispatch), .issue_stall(issue_stall)
    );

    task automatic offer(input int w, input int s1, input int s2,
                         input logic rdv, input int d, input logic mem);
        in_valid    = 1'b1;
        in_warp     = WW'(w);
        in_rs1      = RW'(s1);
        in_rs2      = RW'(s2);
        in_rd_valid = rdv;
        in_rd       = RW'(d);
        in_is_mem   = mem;
    endtask

    task automatic no_offer();
        in_valid = 1'b0;
    endtask

    task automatic wb(input logic v, input int w, input int d);
        wb_valid = v;
        wb_warp  = WW'(w);
        wb_rd    = RW'(d);
    endtask

    // advance to the next falling edge; inputs are then driven, outputs sampled 1 time unit later
    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic e, input logic l, input logic s, input string req);
        #1;
        checks++;
        if (exe_dispatch !== e || lsu_dispatch !== l || issue_stall !== s) begin
            failures++;
            $display("FAIL %s: got exe=%b lsu=%b stall=%b, expected exe=%b lsu=%b stall=%b",
                     req, exe_dispatch, lsu_dispatch, issue_stall, e, l, s);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        no_offer();
        offer(0, 0, 0, 1'b0, 0, 1'b0);
        in_valid = 1'b0;
        lsu_busy = 1'b0;
        wb(1'b0, 0, 0);
        repeat (3) next_cycle();
        expect_out(1'b0, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        next_cycle();
        expect_out(1'b0, 1'b0, 1'b0, "R1 after reset");

        // Sweep over every warp and every tracked register
        for (int w = 0; w < NW; w++) begin
            for (int r = 1; r < NR; r++) begin
                int ow;
                ow = (w + 1) % NW;
                offer(w, 0, 0, 1'b1, r, 1'b0);          // A: writes r, no sources (R2)
                expect_out(1'b0, 1'b0, 1'b0, "R10 empty slot accepts");
                next_cycle();
                offer(ow, r, 0, 1'b0, 0, 1'b0);         // B: other warp reads r
                expect_out(1'b1, 1'b0, 1'b0, "R5 A goes to EXE");
                next_cycle();
                offer(w, 0, r, 1'b0, 0, 1'b1);          // C: same warp reads r, load
                expect_out(1'b1, 1'b0, 1'b0, "R3 other warp not blocked");
                next_cycle();
                no_offer();
                wb(1'b1, w, r);
                expect_out(1'b0, 1'b0, 1'b1, "R4 dest marked, dependent stalls");
                next_cycle();
                wb(1'b0, 0, 0);
                expect_out(1'b0, 1'b1, 1'b0, "R4 writeback releases to LSU");
                next_cycle();
            end
        end
        expect_out(1'b0, 1'b0, 1'b0, "R10 slot drains");

        // LSU busy holds memory ops; offered instruction during stall is dropped
        lsu_busy = 1'b1;
        offer(1, 0, 0, 1'b1, 6, 1'b1);
        next_cycle();
        offer(2, 0, 0, 1'b0, 0, 1'b0);                  // offered while stalled
        expect_out(1'b0, 1'b0, 1'b1, "R6 busy LSU stalls load");
        next_cycle();
        no_offer();
        expect_out(1'b0, 1'b0, 1'b1, "R7 stall persists");
        next_cycle();
        lsu_busy = 1'b0;
        expect_out(1'b0, 1'b1, 1'b0, "R6 LSU free dispatch");
        next_cycle();
        expect_out(1'b0, 1'b0, 1'b0, "R10 stalled offer dropped");
        wb(1'b1, 1, 6);
        next_cycle();
        wb(1'b0, 0, 0);

        lsu_busy = 1'b1;
        offer(3, 0, 0, 1'b0, 0, 1'b0);
        next_cycle();
        no_offer();
        expect_out(1'b1, 1'b0, 1'b0, "R6 EXE ignores busy LSU");
        next_cycle();
        lsu_busy = 1'b0;

        // Absent destination marks nothing
        offer(1, 0, 0, 1'b0, 5, 1'b0);
        next_cycle();
        offer(1, 5, 5, 1'b0, 0, 1'b0);
        expect_out(1'b1, 1'b0, 1'b0, "R9 absent dest dispatch");
        next_cycle();
        no_offer();
        expect_out(1'b1, 1'b0, 1'b0, "R9 reader of r5 not stalled");
        next_cycle();

        // Destination 0 marks nothing
        offer(0, 0, 0, 1'b1, 0, 1'b0);
        next_cycle();
        offer(0, 0, 0, 1'b0, 0, 1'b1);
        expect_out(1'b1, 1'b0, 1'b0, "R2 rd0 dispatch");
        next_cycle();
        no_offer();
        expect_out(1'b0, 1'b1, 1'b0, "R2 source 0 unchecked");
        next_cycle();

        // Writeback and dispatch on the same register in one cycle
        offer(2, 0, 0, 1'b1, 3, 1'b0);
        next_cycle();
        offer(2, 3, 0, 1'b0, 0, 1'b0);
        wb(1'b1, 2, 3);
        expect_out(1'b1, 1'b0, 1'b0, "R8 writer dispatch");
        next_cycle();
        no_offer();
        wb(1'b0, 0, 0);
        expect_out(1'b0, 1'b0, 1'b1, "R8 mark wins over clear");
        next_cycle();
        wb(1'b1, 2, 3);
        expect_out(1'b0, 1'b0, 1'b1, "R4 still stalled in writeback cycle");
        next_cycle();
        wb(1'b0, 0, 0);
        expect_out(1'b1, 1'b0, 1'b0, "R4 released after writeback");
        next_cycle();
        expect_out(1'b0, 1'b0, 1'b0, "R7 idle after release");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule